// File: doc/BRIEF.md
# Single-Edge Match PWM Unit

This block drives a small group of pulse-width outputs from one shared 16-bit up-counter. A period register decides where the counter returns to zero, so a full cycle lasts period+1 counted ticks. Each channel owns a compare value. While the channel is in pulse mode, its output rises when the counter reaches that value and falls when the counter wraps. The duty therefore covers the part of the cycle from the compare point up to the end of the period.

A channel that is not in pulse mode passes through a per-channel level that arrives on an input port. Software-side configuration enters through a plain write strobe with an address and a data word. The counter only moves on cycles where an upstream divider asserts a tick strobe. Capture, interrupts, the bus decoder and the divider itself sit outside this block.

Top module: `se_pwm_unit`

## Requirements
- R1: After reset the counter reads 0, all compare values, the period and the pulse-mode enables are 0, and every output equals its ext_match_i bit.
- R2: The counter holds its value on any cycle without tick_i and, when it is not equal to the period, rises by one (modulo 2^16) on a cycle with tick_i.
- R3: On a tick cycle where the counter equals the period value, the counter becomes 0 at that clock edge.
- R4: A pulse-mode channel whose compare value is below the period drives its output high from the edge at which the counter becomes equal to the compare value.
- R5: On a wrapping tick, every pulse-mode output is cleared unless rule R6 applies to that channel.
- R6: A pulse-mode channel with compare value 0 and a nonzero period is set on the wrapping tick, since set wins over clear, so it stays high without a gap.
- R7: A pulse-mode channel whose compare value is greater than or equal to the period stays low for the whole cycle that follows a wrap.
- R8: While a channel's enable bit is 0, its output equals its ext_match_i bit in the same cycle, whatever the counter does; once enabled, it starts low.
- R9: A write with wr_en_i high loads a compare register at addresses 0 to 2 (channel number equals address), the period at address 3, and the enable bits from wr_data_i[2:0] (bit n for channel n) at address 4; addresses 5 to 7 change nothing; a write takes effect at the next edge, so a tick in the same cycle still uses the old values.
- R10: Channels are independent: each output depends only on its own compare value, enable bit and external bit, together with the shared counter and period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counter advance strobe from the divider |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 3 | Configuration register select |
| wr_data_i | input | 16 | Configuration write data |
| ext_match_i | input | 3 | Per-channel level used when pulse mode is off |
| pwm_o | output | 3 | Channel outputs |
| count_o | output | 16 | Current counter value |

## Verification
The set at a compare point and the clear at the wrap meet in one cycle when a channel's compare value is 0. The same cycle also holds the counter's return to zero. The bench sets a compare value of 0 with a small period and runs unbroken ticks through several wraps. It expects the output to stay high across each wrap edge while channels with nonzero compare values drop. Random runs also land configuration writes on wrapping ticks, where the old period must still decide the wrap and the new values must apply only from the next edge.

// File: rtl/se_pwm_pkg.sv
package se_pwm_pkg;
   // Role decoded from a configuration address.
   typedef enum logic [1:0] {
      ACC_MATCH  = 2'd0,
      ACC_PERIOD = 2'd1,
      ACC_ENABLE = 2'd2,
      ACC_NONE   = 2'd3
   } acc_kind_e;

   function automatic acc_kind_e decode_acc(input int unsigned addr, input int unsigned n_ch);
      if (addr < n_ch)           return ACC_MATCH;
      else if (addr == n_ch)     return ACC_PERIOD;
      else if (addr == n_ch + 1) return ACC_ENABLE;
      else                       return ACC_NONE;
   endfunction
endpackage

// File: rtl/se_pwm_cfg.sv
module se_pwm_cfg
   import se_pwm_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 3,
   parameter int ADDR_W = 3
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          wr_en_i,
   input  logic [ADDR_W-1:0]             wr_addr_i,
   input  logic [CNT_W-1:0]              wr_data_i,
   output logic [NUM_CH-1:0][CNT_W-1:0]  match_o,
   output logic [CNT_W-1:0]              period_o,
   output logic [NUM_CH-1:0]             en_o
);
   acc_kind_e kind;

   always_comb kind = decode_acc(int'(wr_addr_i), NUM_CH);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_match
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            match_o[c] <= '0;
         else if (wr_en_i && kind == ACC_MATCH && int'(wr_addr_i) == c)
            match_o[c] <= wr_data_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         period_o <= '0;
         en_o     <= '0;
      end else if (wr_en_i) begin
         if (kind == ACC_PERIOD) period_o <= wr_data_i;
         if (kind == ACC_ENABLE) en_o     <= wr_data_i[NUM_CH-1:0];
      end
   end
endmodule

// File: rtl/se_pwm_timer.sv
module se_pwm_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] period_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] count_nxt_o,
   output logic             wrap_o
);
   always_comb begin
      wrap_o      = tick_i && (count_o == period_i);
      count_nxt_o = count_o;
      if (wrap_o)      count_nxt_o = '0;
      else if (tick_i) count_nxt_o = count_o + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) count_o <= '0;
      else         count_o <= count_nxt_o;
   end

   assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(count_o));
   assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && count_o != period_i) |=> count_o == CNT_W'($past(count_o) + 1'b1));
   assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && count_o == period_i) |=> count_o == '0);
endmodule

// File: rtl/se_pwm_channel.sv
module se_pwm_channel #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic             wrap_i,
   input  logic [CNT_W-1:0] count_nxt_i,
   input  logic [CNT_W-1:0] match_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             level_o
);
   logic hit;

   always_comb hit = tick_i && (match_i < period_i) && (count_nxt_i == match_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      level_o <= 1'b0;
      else if (!en_i)   level_o <= 1'b0;
      else if (hit)     level_o <= 1'b1;
      else if (wrap_i)  level_o <= 1'b0;
   end

   assert_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && tick_i && match_i < period_i && count_nxt_i == match_i) |=> level_o);
   assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && wrap_i && match_i != '0) |=> !level_o);
   assert_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && wrap_i && match_i == '0 && period_i != '0) |=> level_o);
   assert_start_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !level_o);
endmodule

// File: rtl/se_pwm_unit.sv
module se_pwm_unit #(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 3,
   parameter int ADDR_W = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [CNT_W-1:0]  wr_data_i,
   input  logic [NUM_CH-1:0] ext_match_i,
   output logic [NUM_CH-1:0] pwm_o,
   output logic [CNT_W-1:0]  count_o
);
   localparam int N_REGS = NUM_CH + 2;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("se_pwm_unit: CNT_W must be within 2..32");
   end
   if (NUM_CH < 1 || NUM_CH > CNT_W) begin : g_bad_ch
      $error("se_pwm_unit: NUM_CH must be within 1..CNT_W");
   end
   if (N_REGS > (1 << ADDR_W)) begin : g_bad_addr
      $error("se_pwm_unit: ADDR_W too narrow for the register set");
   end

   logic [NUM_CH-1:0][CNT_W-1:0] match_q;
   logic [CNT_W-1:0]             period_q;
   logic [NUM_CH-1:0]            en_q;
   logic [CNT_W-1:0]             count_nxt;
   logic                         wrap;
   logic [NUM_CH-1:0]            level;

   se_pwm_cfg #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_cfg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .match_o   (match_q),
      .period_o  (period_q),
      .en_o      (en_q)
   );

   se_pwm_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick_i),
      .period_i    (period_q),
      .count_o     (count_o),
      .count_nxt_o (count_nxt),
      .wrap_o      (wrap)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      se_pwm_channel #(.CNT_W(CNT_W)) u_ch (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .en_i        (en_q[c]),
         .tick_i      (tick_i),
         .wrap_i      (wrap),
         .count_nxt_i (count_nxt),
         .match_i     (match_q[c]),
         .period_i    (period_q),
         .level_o     (level[c])
      );
      // R8 / R10: per-channel source select
      always_comb pwm_o[c] = en_q[c] ? level[c] : ext_match_i[c];
   end
endmodule

// File: tb/tb_se_pwm_unit.sv
module tb_se_pwm_unit;
   localparam int CW = 16;
   localparam int NC = 3;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic [NC-1:0] ext = '0;
   logic [NC-1:0] pwm;
   logic [CW-1:0] count;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // bench model state
   logic [CW-1:0] m_cnt = '0;
   logic [CW-1:0] m_per = '0;
   logic [CW-1:0] m_mat [NC];
   logic [NC-1:0] m_en = '0;
   logic [NC-1:0] m_q = '0;

   always #10 clk = ~clk;

   se_pwm_unit #(.CNT_W(CW), .NUM_CH(NC), .ADDR_W(AW)) dut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
      .wr_addr_i(wr_addr), .wr_data_i(wr_data), .ext_match_i(ext),
      .pwm_o(pwm), .count_o(count)
   );

   function automatic logic exp_out(int c);
      return m_en[c] ? m_q[c] : ext[c];
   endfunction

   function automatic string tag_for(int c);
      if (!m_en[c])              return "R8";
      if (m_mat[c] >= m_per)     return "R7";
      if (m_mat[c] == '0)        return "R6";
      if (m_cnt == '0)           return "R5";
      return "R4";
   endfunction

   task automatic check(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check("R2", count, m_cnt);
      for (int c = 0; c < NC; c++)
         check(tag_for(c), CW'(pwm[c]), CW'(exp_out(c)));
   endtask

   // one clock: drive at negedge, model at posedge, compare at next negedge
   task automatic step(logic t, logic w, logic [AW-1:0] a, logic [CW-1:0] d, logic [NC-1:0] e);
      logic [CW-1:0] nc;
      tick = t; wr_en = w; wr_addr = a; wr_data = d; ext = e;
      @(posedge clk);
      nc = m_cnt;
      if (t) nc = (m_cnt == m_per) ? '0 : m_cnt + 1'b1;
      for (int c = 0; c < NC; c++) begin
         if (!m_en[c]) m_q[c] = 1'b0;
         else if (t && m_mat[c] < m_per && nc == m_mat[c]) m_q[c] = 1'b1;
         else if (t && m_cnt == m_per) m_q[c] = 1'b0;
      end
      m_cnt = nc;
      if (w) begin   // R9 decode: 0..2 compare, 3 period, 4 enables, rest ignored
         if (a < 3)       m_mat[a] = d;
         else if (a == 3) m_per = d;
         else if (a == 4) m_en = d[NC-1:0];
      end
      @(negedge clk);
      compare_all();
   endtask

   task automatic wr(logic [AW-1:0] a, logic [CW-1:0] d);
      step(1'b0, 1'b1, a, d, ext);
   endtask

   initial begin
      int unsigned seed;
      logic [NC-1:0] hist;
      for (int c = 0; c < NC; c++) m_mat[c] = '0;
      seed = 32'd1234;
      void'($urandom(seed));
      ext = 3'b101;
      repeat (3) @(negedge clk);
      // R1: reset state, outputs follow ext
      check("R1", count, '0);
      check("R1", CW'(pwm), CW'(3'b101));
      rst_n = 1'b1;
      @(negedge clk);
      ext = 3'b010;
      #1 check("R1", CW'(pwm), CW'(3'b010));

      // directed: period 5, compares 2 / 0 / 7, all enabled
      wr(3'd3, 16'd5);
      wr(3'd0, 16'd2);
      wr(3'd1, 16'd0);
      wr(3'd2, 16'd7);
      wr(3'd4, 16'h0007);
      // R8: enabled channels start low
      check("R8", CW'(pwm), '0);
      // R6: channel 1 high across wraps; R5: channel 0 drops at each wrap
      hist = '0;
      for (int k = 0; k < 18; k++) begin
         step(1'b1, 1'b0, '0, '0, ext);
         if (count == 16'd0 && k > 6) begin
            check("R5", CW'(pwm[0]), '0);
            check("R6", CW'(pwm[1]), 16'd1);
            check("R7", CW'(pwm[2]), '0);
         end
         if (count == 16'd2) check("R4", CW'(pwm[0]), 16'd1);
      end
      // R9: writes to unused addresses leave everything alone
      wr(3'd5, 16'h0000);
      wr(3'd6, 16'h0000);
      wr(3'd7, 16'h0001);
      check("R9", CW'(m_en), 16'd7);
      // R9: write on a wrapping tick uses old period for that wrap
      while (count != 16'd5) step(1'b1, 1'b0, '0, '0, ext);
      step(1'b1, 1'b1, 3'd3, 16'd3, ext);
      check("R3", count, '0);
      // R10 / R8: disable channel 1 only, it follows ext, others keep pulsing
      wr(3'd4, 16'h0005);
      for (int k = 0; k < 10; k++)
         step(1'b1, 1'b0, '0, '0, NC'($urandom));
      check("R10", CW'(m_en), 16'd5);

      // constrained random
      for (int k = 0; k < 4000; k++) begin
         logic t, w;
         logic [AW-1:0] a;
         logic [CW-1:0] d;
         t = ($urandom % 4) != 0;
         w = ($urandom % 20) == 0;
         a = AW'($urandom % 8);
         d = CW'($urandom % 24);
         if (a == 3'd4) d = CW'($urandom % 8);
         step(t, w, a, d, NC'($urandom));
      end
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule